// File: doc/BRIEF.md
# Programmable LED Blinker with Autostop

This block drives one LED with a repeating on/off waveform. A free-running prescaler is cleared while the LED is disabled. A 4-bit rate field sets its rate in powers of two. Each prescaler tick advances a period counter. The LED is lit while that counter is below a programmed duty value. Software programs the block through a small word-addressed register port with one write strobe and a combinational read path.

An optional autostop mode counts completed periods down from a programmed value. When the count runs out, hardware clears the enable bit and the LED goes dark. The block can also raise a one-cycle interrupt pulse, which a mask bit in the control register suppresses. The clock source and pin multiplexing sit outside this block.

Top module: `led_blink`

## Requirements
- R1: After reset all registers read zero, `led_o` is low and `irq_o` is low.
- R2: Registers sit at byte offsets 0x0 (control, 7 bits), 0x4 (period, 12 bits), 0x8 (duty, 12 bits) and 0xC (autostop count, 16 bits). The control fields are rate [3:0], enable [4], autostop enable [5] and interrupt mask [6]. Unused read bits return zero, and writes to unaligned offsets are ignored.
- R3: A rate value above 13 is stored and read back as 13.
- R4: With rate n, a tick occurs every 2^(13-n) clocks, and the first tick comes 2^(13-n) clocks after enable. The prescaler is held cleared while the LED is disabled.
- R5: The period counter starts at 0 on enable and advances once per tick. It returns to 0 after reaching period-1, so a period of 0 behaves as 1. The LED is high while the counter is below duty.
- R6: A duty of 0 keeps the LED off. A duty greater than or equal to the period keeps it constantly on.
- R7: While the enable bit is 0 the LED is low.
- R8: With autostop enabled, each completed period decrements the count. The period that finds a count of 1 or 0 sets the count to 0, clears the enable bit and turns the LED off on the next cycle.
- R9: At an autostop stop, `irq_o` is high for exactly one cycle, the cycle after the last period ends, unless the mask bit is 1. With the mask bit set it stays low.
- R10: With autostop disabled the count register is not changed by running periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register byte offset |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` (combinational) |
| led_o | output | 1 | LED drive |
| irq_o | output | 1 | Autostop interrupt pulse |

## Verification
The single-cycle interrupt check assumes software never rewrites the control register with enable set in the same cycle that an autostop stop fires. Such a write takes priority and could cause back-to-back stops. The stimulus only writes the control register while the LED is idle or before a run begins. The check that the count never rises outside a write assumes the count changes only through the count register. The bench makes no other writes during a run.

// File: rtl/led_blink_pkg.sv
package led_blink_pkg;
  localparam int unsigned RATE_W   = 4;
  localparam int unsigned RATE_MAX = 13;
  localparam int unsigned PER_W    = 12;
  localparam int unsigned STOP_W   = 16;
  localparam int unsigned DATA_W   = 16;

  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_PER   = 2'd1,
    REG_DUTY  = 2'd2,
    REG_COUNT = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic              irq_mask;
    logic              auto_en;
    logic              run;
    logic [RATE_W-1:0] rate;
  } ctrl_t;

  function automatic logic [RATE_W-1:0] clamp_rate(input logic [RATE_W-1:0] r);
    return (r > RATE_W'(RATE_MAX)) ? RATE_W'(RATE_MAX) : r;
  endfunction
endpackage

// File: rtl/led_prescaler.sv
module led_prescaler #(
  parameter int unsigned RATE_W   = 4,
  parameter int unsigned RATE_MAX = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              tick_o
);
  localparam int unsigned PRE_W = RATE_MAX;

  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] mask;

  // rate 0 -> full mask (slowest), rate RATE_MAX -> every cycle
  assign mask   = {PRE_W{1'b1}} >> rate_i;
  assign tick_o = run_i && ((cnt_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // R3
  rate_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rate_i <= RATE_W'(RATE_MAX));
endmodule

// File: rtl/led_waveform.sv
module led_waveform #(
  parameter int unsigned PER_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [PER_W-1:0] period_i,
  input  logic [PER_W-1:0] duty_i,
  output logic             led_o,
  output logic             period_done_o
);
  logic [PER_W-1:0] pc_q;
  logic             last;

  // period 0 acts as 1
  assign last          = ({1'b0, pc_q} + 1'b1) >= {1'b0, period_i};
  assign period_done_o = tick_i && last;
  assign led_o         = run_i && (pc_q < duty_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pc_q <= '0;
    else if (!run_i) pc_q <= '0;
    else if (tick_i) pc_q <= last ? '0 : pc_q + 1'b1;
  end

  // R5
  wrap_to_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_done_o |=> (pc_q == '0));
endmodule

// File: rtl/led_autostop.sv
module led_autostop #(
  parameter int unsigned STOP_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_cnt_i,
  input  logic [STOP_W-1:0] wdata_i,
  input  logic              run_i,
  input  logic              auto_en_i,
  input  logic              irq_mask_i,
  input  logic              period_done_i,
  output logic [STOP_W-1:0] cnt_o,
  output logic              stop_o,
  output logic              irq_o
);
  logic [STOP_W-1:0] cnt_q;
  logic              irq_q;
  logic              step;

  assign step   = period_done_i && run_i && auto_en_i;
  assign stop_o = step && (cnt_q <= STOP_W'(1));
  assign cnt_o  = cnt_q;
  assign irq_o  = irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= stop_o && !irq_mask_i;
      if (wr_cnt_i)    cnt_q <= wdata_i;
      else if (stop_o) cnt_q <= '0;
      else if (step)   cnt_q <= cnt_q - 1'b1;
    end
  end

  // R8
  count_no_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_cnt_i |=> cnt_q <= $past(cnt_q));
  // R9
  irq_single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |=> !irq_q);
endmodule

// File: rtl/led_blink.sv
module led_blink
  import led_blink_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              led_o,
  output logic              irq_o
);
  ctrl_t             ctrl_q;
  logic [PER_W-1:0]  period_q, duty_q;
  logic [STOP_W-1:0] cnt;
  logic              aligned, tick, period_done, stop;
  reg_sel_e          sel;

  assign aligned = (addr_i[1:0] == 2'b00);
  assign sel     = reg_sel_e'(addr_i[3:2]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      period_q <= '0;
      duty_q   <= '0;
    end else begin
      if (wr_en_i && aligned && sel == REG_CTRL) begin
        ctrl_q.rate     <= clamp_rate(wdata_i[RATE_W-1:0]);
        ctrl_q.run      <= wdata_i[RATE_W];
        ctrl_q.auto_en  <= wdata_i[RATE_W+1];
        ctrl_q.irq_mask <= wdata_i[RATE_W+2];
      end else if (stop) begin
        ctrl_q.run <= 1'b0;
      end
      if (wr_en_i && aligned && sel == REG_PER)  period_q <= wdata_i[PER_W-1:0];
      if (wr_en_i && aligned && sel == REG_DUTY) duty_q   <= wdata_i[PER_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (aligned) begin
      unique case (sel)
        REG_CTRL:  rdata_o = DATA_W'(ctrl_q);
        REG_PER:   rdata_o = DATA_W'(period_q);
        REG_DUTY:  rdata_o = DATA_W'(duty_q);
        REG_COUNT: rdata_o = DATA_W'(cnt);
        default:   rdata_o = '0;
      endcase
    end
  end

  led_prescaler #(.RATE_W(RATE_W), .RATE_MAX(RATE_MAX)) u_pre (
    .clk_i, .rst_ni, .run_i(ctrl_q.run), .rate_i(ctrl_q.rate), .tick_o(tick)
  );

  led_waveform #(.PER_W(PER_W)) u_wave (
    .clk_i, .rst_ni, .run_i(ctrl_q.run), .tick_i(tick),
    .period_i(period_q), .duty_i(duty_q),
    .led_o, .period_done_o(period_done)
  );

  led_autostop #(.STOP_W(STOP_W)) u_stop (
    .clk_i, .rst_ni,
    .wr_cnt_i(wr_en_i && aligned && sel == REG_COUNT),
    .wdata_i(wdata_i[STOP_W-1:0]),
    .run_i(ctrl_q.run), .auto_en_i(ctrl_q.auto_en), .irq_mask_i(ctrl_q.irq_mask),
    .period_done_i(period_done),
    .cnt_o(cnt), .stop_o(stop), .irq_o
  );

  // R7
  dark_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q.run |-> !led_o);
  // R8
  stop_clears_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop && !(wr_en_i && aligned && sel == REG_CTRL)) |=> !ctrl_q.run);
endmodule

// File: tb/led_blink_tb.sv
`timescale 1ns/1ps
module led_blink_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        led, irq;
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  led_blink u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .led_o(led), .irq_o(irq)
  );

  localparam int NV = 8;
  // rate, period, duty, window cycles, expected lit cycles
  localparam int V_RATE [NV] = '{13, 13, 12, 15, 13, 13, 13, 11};
  localparam int V_PER  [NV] = '{ 4,  5,  4,  3,  4,  4,  6,  2};
  localparam int V_DUTY [NV] = '{ 1,  3,  2,  1,  4,  9,  0,  1};
  localparam int V_WIN  [NV] = '{ 8, 10, 16,  6,  8,  8, 12, 16};
  localparam int V_EXP  [NV] = '{ 2,  6,  8,  2,  8,  8,  0,  8};

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output int v);
    addr = a;
    #1;
    v = int'(rdata);
  endtask

  function automatic logic [15:0] ctrl(input int rate, input bit en, input bit as, input bit msk);
    return {9'd0, msk, as, en, 4'(rate)};
  endfunction

  initial begin
    int v, lit, irqs, irq_at;
    repeat (3) @(negedge clk);
    // R1
    check("R1 led", int'(led), 0);
    check("R1 irq", int'(irq), 0);
    for (int a = 0; a < 4; a++) begin
      rd(4'(a * 4), v);
      check("R1 reg", v, 0);
    end
    rst_n = 1'b1;
    // R2 map and widths
    wr(4'h4, 16'hFABC); rd(4'h4, v); check("R2 period width", v, 16'h0ABC);
    wr(4'h8, 16'hF123); rd(4'h8, v); check("R2 duty width", v, 16'h0123);
    wr(4'hC, 16'hBEEF); rd(4'hC, v); check("R2 count", v, 16'hBEEF);
    wr(4'h5, 16'h0007); rd(4'h4, v); check("R2 unaligned ignored", v, 16'h0ABC);
    wr(4'h0, 16'hFF8C); rd(4'h0, v); check("R2 ctrl width", v, 16'h000C);
    // R3
    wr(4'h0, 16'h000F); rd(4'h0, v); check("R3 clamp", v, 13);
    wr(4'h0, 16'h0000);

    // R4 R5 R6 vector table
    for (int i = 0; i < NV; i++) begin
      wr(4'h0, 16'h0000);
      wr(4'h4, 16'(V_PER[i]));
      wr(4'h8, 16'(V_DUTY[i]));
      wr(4'h0, ctrl(V_RATE[i], 1'b1, 1'b0, 1'b0));
      lit = 0;
      for (int c = 0; c < V_WIN[i]; c++) begin
        lit += int'(led);
        @(negedge clk);
      end
      check($sformatf("R4 R5 R6 vector %0d lit", i), lit, V_EXP[i]);
    end

    // R7 disable darkens LED
    wr(4'h0, 16'h0000);
    @(negedge clk);
    check("R7 off", int'(led), 0);

    // R8 R9 autostop, unmasked
    wr(4'h4, 16'd3); wr(4'h8, 16'd1); wr(4'hC, 16'd2);
    wr(4'h0, ctrl(13, 1'b1, 1'b1, 1'b0));
    lit = 0; irqs = 0; irq_at = -1;
    for (int c = 0; c < 10; c++) begin
      lit += int'(led);
      if (irq) begin irqs++; irq_at = c; end
      @(negedge clk);
    end
    check("R8 lit before stop", lit, 2);
    check("R9 irq count", irqs, 1);
    check("R9 irq cycle", irq_at, 6);
    rd(4'h0, v); check("R8 enable cleared", (v >> 4) & 1, 0);
    rd(4'hC, v); check("R8 count zero", v, 0);

    // R9 masked
    wr(4'hC, 16'd1);
    wr(4'h0, ctrl(13, 1'b1, 1'b1, 1'b1));
    irqs = 0;
    for (int c = 0; c < 8; c++) begin
      if (irq) irqs++;
      @(negedge clk);
    end
    check("R9 masked irq", irqs, 0);
    rd(4'h0, v); check("R8 masked stop", (v >> 4) & 1, 0);

    // R10 autostop off keeps count
    wr(4'hC, 16'd2);
    wr(4'h0, ctrl(13, 1'b1, 1'b0, 1'b0));
    repeat (12) @(negedge clk);
    rd(4'hC, v); check("R10 count held", v, 2);
    rd(4'h0, v); check("R10 still running", (v >> 4) & 1, 1);
    wr(4'h0, 16'h0000);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule